// File: doc/BRIEF.md
# Banked Register RAM Window

This block is the register-file address decoder of a small processor, together with the storage behind it. The CPU presents an 8-bit logical address with a read strobe, a write strobe and write data. Most logical addresses reach a directly addressed register RAM. A 64-byte slice of the space, logical 080H to 0BFH, is a window onto a larger banked RAM. A bank-select register chooses which physical bank that window shows. The bank-select register is writable and readable at logical address FCH.

Inside the window, the 5-bit bank value forms the upper part of an 11-bit physical address. The low six logical address bits form the offset. Twelve banks exist, so physical addresses 000H to 2FFH are backed by 768 bytes. The 5-bit field can also name banks 0CH to 1FH, which have no storage behind them. For those banks the block drops writes, returns zero on reads and raises a one-cycle error pulse. Firmware can use that pulse to catch a stray bank selection. In normal use, 70 direct bytes (03AH to 07FH) and banks 0, A and B make up 262 bytes of user RAM.

Top module: `regwin_bank_window`

## Requirements
- R1: After synchronous reset, the bank-select register is 0, `rd_data` is 00H and `bank_error` is low.
- R2: An access to logical 080H–0BFH with an implemented bank b (0–11) reaches physical byte `{b[4:0], addr[5:0]}`. The same logical address under different banks therefore holds independent data.
- R3: A write to logical FCH loads `wr_data[4:0]` into the bank-select register. A read of FCH returns the register with bits [7:5] as zero.
- R4: A bank-select write takes effect for the very next access, in the following cycle.
- R5: Logical addresses outside 080H–0BFH other than FCH store and return data regardless of the bank-select value.
- R6: A write into the window while the bank value is 0CH–1FH changes no stored byte in any bank.
- R7: A read from the window while the bank value is 0CH–1FH returns 00H.
- R8: `bank_error` is high for exactly the one cycle after a read or write into the window made with a bank value of 0CH–1FH. It stays low for accesses to direct addresses or FCH, for idle cycles, and for accesses made with an implemented bank.
- R9: Read data appears on `rd_data` in the cycle after the read strobe and holds until the next read strobe.
- R10: When read and write strobes are both asserted for the same address, the read returns the byte stored before the write.
- R11: The window's edges are exact. Offsets 00H and 3FH (logical 080H and 0BFH) are banked, and logical 07FH and 0C0H are direct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Logical register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| bank_error | output | 1 | One-cycle pulse after a window access with an unimplemented bank |

## Verification
The bench stores a distinct signature at offsets 00H, 05H and 3FH of every implemented bank and reads each one back. A decoder that dropped or swapped a bank bit would alias two banks and return the wrong signature. It then selects banks 0CH and 1FH and writes into the window. A design that wrapped the bank index into the implemented range would corrupt banks 0 or B, which the later sweep of all banks exposes. The same step also catches a design that returned stale data or missed the error pulse. Further checks cover the 07FH and 0C0H edges, a bank switch followed at once by an access, the read-before-write ordering of simultaneous strobes, and the masking of the upper bits of the bank-select register.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int ADDR_W         = 8;
    localparam int DATA_W         = 8;
    localparam int OFF_W          = 6;
    localparam int BANK_W         = 5;
    localparam int NUM_BANKS      = 12;
    localparam int PHYS_W         = BANK_W + OFF_W;
    localparam int BANK_RAM_DEPTH = NUM_BANKS << OFF_W;
    localparam int DIRECT_DEPTH   = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] WIN_BASE      = 8'h80;
    localparam logic [ADDR_W-1:0] BANK_SEL_ADDR = 8'hFC;

    typedef enum logic [1:0] {
        REG_DIRECT,
        REG_WINDOW,
        REG_BANKSEL
    } region_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_DIRECT,
        SRC_BANKED,
        SRC_SELECT
    } rsrc_e;

    typedef struct packed {
        region_e           region;
        logic              bank_ok;
        logic [PHYS_W-1:0] phys;
    } xlate_t;

    function automatic logic hits_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W];
    endfunction

    function automatic logic bank_present(input logic [BANK_W-1:0] b);
        return b < BANK_W'(NUM_BANKS);
    endfunction

endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
    import regwin_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output xlate_t            xl
);

    always_comb begin
        if (addr == BANK_SEL_ADDR) begin
            xl.region = REG_BANKSEL;
        end else if (hits_window(addr)) begin
            xl.region = REG_WINDOW;
        end else begin
            xl.region = REG_DIRECT;
        end
        xl.bank_ok = bank_present(bank);
        xl.phys    = {bank, addr[OFF_W-1:0]};
    end

endmodule

// File: rtl/regwin_bank_sel.sv
module regwin_bank_sel
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] wr_bank,
    output logic [BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0] rd_q
);

    localparam int PAD_W = DATA_W - BANK_W;

    logic [DATA_W-1:0] bank_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign bank_ext = {{PAD_W{1'b0}}, bank_q};
        end else begin : g_nopad
            assign bank_ext = bank_q[DATA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            rd_q   <= '0;
        end else begin
            if (rd_en) begin
                rd_q <= bank_ext;
            end
            if (wr_en) begin
                bank_q <= wr_bank;
            end
        end
    end

endmodule

// File: rtl/regwin_sram.sv
module regwin_sram #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rq
);

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wd;
        end
        if (re) begin
            rq <= mem[addr];
        end
    end

endmodule

// File: rtl/regwin_bank_window.sv
module regwin_bank_window
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              bank_error
);

    logic [BANK_W-1:0] bank_q;
    xlate_t            xl;

    logic sel_we, sel_re;
    logic bk_we, bk_re;
    logic dir_we, dir_re;
    logic bad_access;

    logic [DATA_W-1:0] sel_rd, bk_rd, dir_rd;
    rsrc_e             src_q, src_d;

    regwin_xlate u_xlate (
        .addr (addr),
        .bank (bank_q),
        .xl   (xl)
    );

    always_comb begin
        sel_we     = 1'b0;
        sel_re     = 1'b0;
        bk_we      = 1'b0;
        bk_re      = 1'b0;
        dir_we     = 1'b0;
        dir_re     = 1'b0;
        bad_access = 1'b0;
        src_d      = SRC_NONE;
        unique case (xl.region)
            REG_BANKSEL: begin
                sel_we = wr_en;
                sel_re = rd_en;
                src_d  = SRC_SELECT;
            end
            REG_WINDOW: begin
                bk_we      = wr_en && xl.bank_ok;
                bk_re      = rd_en && xl.bank_ok;
                bad_access = (wr_en || rd_en) && !xl.bank_ok;
                src_d      = xl.bank_ok ? SRC_BANKED : SRC_NONE;
            end
            default: begin
                dir_we = wr_en;
                dir_re = rd_en;
                src_d  = SRC_DIRECT;
            end
        endcase
    end

    regwin_bank_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel_we),
        .rd_en   (sel_re),
        .wr_bank (wr_data[BANK_W-1:0]),
        .bank_q  (bank_q),
        .rd_q    (sel_rd)
    );

    regwin_sram #(
        .DEPTH (BANK_RAM_DEPTH),
        .AW    (PHYS_W),
        .DW    (DATA_W)
    ) u_banked (
        .clk  (clk),
        .we   (bk_we),
        .re   (bk_re),
        .addr (xl.phys),
        .wd   (wr_data),
        .rq   (bk_rd)
    );

    regwin_sram #(
        .DEPTH (DIRECT_DEPTH),
        .AW    (ADDR_W),
        .DW    (DATA_W)
    ) u_direct (
        .clk  (clk),
        .we   (dir_we),
        .re   (dir_re),
        .addr (addr),
        .wd   (wr_data),
        .rq   (dir_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= SRC_NONE;
            bank_error <= 1'b0;
        end else begin
            bank_error <= bad_access;
            if (rd_en) begin
                src_q <= src_d;
            end
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_DIRECT: rd_data = dir_rd;
            SRC_BANKED: rd_data = bk_rd;
            SRC_SELECT: rd_data = sel_rd;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/regwin_checker.sv
module regwin_checker
    import regwin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              bank_error,
    input logic [BANK_W-1:0] bank_q
);

    logic stray;
    assign stray = (wr_en || rd_en) && hits_window(addr) && !bank_present(bank_q);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_q == '0) && !bank_error);  // R1

    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) == BANK_SEL_ADDR && !$past(rst)) |-> rd_data[DATA_W-1:BANK_W] == '0);  // R3

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(wr_en) && $past(addr) == BANK_SEL_ADDR)) |-> $stable(bank_q));  // R4

    AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && bank_error) |-> rd_data == '0);  // R7

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bank_error |-> $past(stray));  // R8

    AST_ERR_ON_STRAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stray)) |-> bank_error);  // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));  // R9

endmodule

bind regwin_bank_window regwin_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .bank_error (bank_error),
    .bank_q     (bank_q)
);

// File: tb/sim_regwin_bank_window.sv
`timescale 1ns/1ps
module sim_regwin_bank_window;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       bank_error;

    always #2 clk = ~clk;

    regwin_bank_window u0 (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .bank_error (bank_error)
    );

    typedef struct {
        logic [7:0] d;
        logic       e;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] mdl_bank   [0:767];
    logic [7:0] mdl_direct [0:255];
    logic [4:0] mdl_sel  = 5'd0;
    logic [7:0] mdl_last = 8'h00;

    task automatic acc(input logic w, input logic r, input logic [7:0] a,
                       input logic [7:0] d, input string tag);
        exp_t it;
        logic win, bad;
        int   idx;
        @(negedge clk);
        wr_en   = w;
        rd_en   = r;
        addr    = a;
        wr_data = d;
        win = (a >= 8'h80) && (a <= 8'hBF);
        bad = (mdl_sel >= 5'd12);
        idx = {mdl_sel, a[5:0]};
        if (r) begin
            if (a == 8'hFC)    mdl_last = {3'b000, mdl_sel};
            else if (win)      mdl_last = bad ? 8'h00 : mdl_bank[idx];
            else               mdl_last = mdl_direct[a];
        end
        if (w) begin
            if (a == 8'hFC)    mdl_sel = d[4:0];
            else if (win) begin
                if (!bad) mdl_bank[idx] = d;
            end else           mdl_direct[a] = d;
        end
        it.d   = mdl_last;
        it.e   = (w || r) && win && bad;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (rd_data !== it.d) begin
                errors++;
                $display("FAIL %s: rd_data=%h expected %h", it.tag, rd_data, it.d);
            end
            checks++;
            if (bank_error !== it.e) begin
                errors++;
                $display("FAIL %s: bank_error=%b expected %b", it.tag, bank_error, it.e);
            end
        end
    end

    function automatic logic [7:0] sig(input int b, input int off);
        return 8'((b * 16 + off) ^ 8'h5A);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state right after reset
        checks++;
        if (rd_data !== 8'h00 || bank_error !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_data=%h bank_error=%b expected 00 0", rd_data, bank_error);
        end
        acc(0, 1, 8'hFC, 8'h00, "R1");

        // R2 / R11: fill offsets 00, 05, 3F of every bank
        for (int b = 0; b < 12; b++) begin
            acc(1, 0, 8'hFC, 8'(b), "R4");
            acc(1, 0, 8'h80, sig(b, 0), "R11");
            acc(1, 0, 8'h85, sig(b, 5), "R2");
            acc(1, 0, 8'hBF, sig(b, 63), "R11");
        end
        for (int b = 0; b < 12; b++) begin
            acc(1, 0, 8'hFC, 8'(b), "R4");
            acc(0, 1, 8'h80, 8'h00, "R11");
            acc(0, 1, 8'h85, 8'h00, "R2");
            acc(0, 1, 8'hBF, 8'h00, "R11");
        end

        // R3: upper written bits are dropped
        acc(1, 0, 8'hFC, 8'hE5, "R3");
        acc(0, 1, 8'hFC, 8'h00, "R3");

        // R4: bank switch followed at once by a window access
        acc(1, 0, 8'hFC, 8'h03, "R4");
        acc(0, 1, 8'h85, 8'h00, "R4");
        acc(1, 0, 8'hFC, 8'h0A, "R4");
        acc(0, 1, 8'hBF, 8'h00, "R4");

        // R5 / R11: direct addresses independent of bank
        acc(1, 0, 8'h3A, 8'h11, "R5");
        acc(1, 0, 8'h7F, 8'h22, "R11");
        acc(1, 0, 8'hC0, 8'h33, "R11");
        acc(1, 0, 8'h10, 8'h44, "R5");
        acc(1, 0, 8'hFC, 8'h07, "R5");
        acc(0, 1, 8'h3A, 8'h00, "R5");
        acc(0, 1, 8'h7F, 8'h00, "R11");
        acc(0, 1, 8'hC0, 8'h00, "R11");
        acc(0, 1, 8'h10, 8'h00, "R5");

        // R6 / R7 / R8: unimplemented banks
        acc(1, 0, 8'hFC, 8'h0C, "R8");
        acc(1, 0, 8'h85, 8'hAA, "R6");
        acc(0, 1, 8'h85, 8'h00, "R7");
        acc(0, 1, 8'hBF, 8'h00, "R7");
        acc(0, 0, 8'h85, 8'h00, "R8");
        acc(0, 1, 8'h3A, 8'h00, "R8");
        acc(1, 0, 8'h7F, 8'h66, "R8");
        acc(1, 0, 8'hFC, 8'h1F, "R8");
        acc(1, 0, 8'hBF, 8'h77, "R6");
        acc(1, 0, 8'h80, 8'h78, "R6");
        acc(0, 1, 8'h80, 8'h00, "R7");
        acc(0, 1, 8'hFC, 8'h00, "R8");
        acc(0, 1, 8'h7F, 8'h00, "R5");
        for (int b = 0; b < 12; b++) begin
            acc(1, 0, 8'hFC, 8'(b), "R6");
            acc(0, 1, 8'h80, 8'h00, "R6");
            acc(0, 1, 8'h85, 8'h00, "R6");
            acc(0, 1, 8'hBF, 8'h00, "R6");
        end

        // R10: simultaneous read and write
        acc(1, 0, 8'hFC, 8'h02, "R10");
        acc(1, 1, 8'h85, 8'hC3, "R10");
        acc(0, 1, 8'h85, 8'h00, "R10");
        acc(1, 1, 8'h10, 8'h5E, "R10");
        acc(0, 1, 8'h10, 8'h00, "R10");
        acc(1, 1, 8'hFC, 8'h09, "R10");
        acc(0, 1, 8'hFC, 8'h00, "R3");

        // R9: data holds without a read strobe
        acc(1, 0, 8'h85, 8'h01, "R9");
        acc(0, 0, 8'h3A, 8'h00, "R9");
        acc(1, 0, 8'h3A, 8'h99, "R9");
        acc(0, 0, 8'h00, 8'h00, "R9");
        acc(0, 0, 8'h00, 8'h00, "R9");

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule